// File: doc/BRIEF.md
# I2C Master Message Sequencer

This block is an I2C master that carries out a complete read or write message once it has been started. A single command word gives the byte count, the direction, whether to end with STOP, and a run trigger. The target address arrives on its own input. The sequencer then produces START or repeated START and the address byte. It moves data bytes between the bus and a pair of byte streams: it pops transmit bytes from an upstream queue and pushes received bytes to a downstream one. It ends the message with STOP, or it parks the bus for a repeated START. The bus is driven open-drain: two outputs request a low level on SCL and on SDA, and the resolved wire levels come back as inputs. Bus timing advances on a clock-enable tick, and one bit period takes four ticks.

A 4-bit state code and five sticky result flags report the progress and outcome of each message. Software reads them to tell success from a missing device, a refused data byte, lost arbitration or a slave that keeps SCL low too long. A manual path handles bus recovery. One command clocks nine pulses with SDA released, and a second command drives a lone STOP. Together they free a slave that is stuck holding SDA low, which the state code reports while the bus is idle.

Top module: `i2c_auto_master`

## Requirements
- R1: A run command (cmd_valid with cmd_word bit 31 set) is taken in state idle (0x0) or hold (0xE). cmd_word[7:0] is the byte count, bit 16 the direction (1 read, 0 write) and bit 17 stop-after-transfer. The address byte sent is {tgt_addr, direction}, and taking a command clears status.
- R2: On a write, bytes are popped from the transmit stream one per tx_pop pulse and sent MSB first. When every byte is acknowledged, status bit 0 (done) is set.
- R3: On a read, each received byte appears on rx_data with a one-cycle rx_valid pulse. The master acknowledges every byte except the last, which it answers with NACK.
- R4: With stop-after-transfer set, the message ends with a STOP condition. busy stays high from the command until that STOP has completed, and the state then reads idle (0x0) with both lines released.
- R5: With stop-after-transfer clear, the message ends without STOP. The state reads hold (0xE) with SCL driven low and busy high, and the next run command starts with a repeated START.
- R6: A NACK to the address byte sets status bit 3, pops no transmit byte and ends with STOP.
- R7: A NACK to a write data byte sets status bit 2 and ends with STOP, even when stop-after-transfer is clear.
- R8: If SDA reads low while the master releases it on an address or write data bit, status bit 1 is set. The state becomes lost (0xC) and both lines are released.
- R9: If SCL stays low longer than tmo_limit ticks (tmo_limit nonzero) during a bit, status bit 4 is set, both lines are released and busy falls.
- R10: While a slave stretches SCL within the limit, the state reads wait (0xD), and the message then completes normally.
- R11: While idle with SDA low, the state reads lost (0xC), and a run command is ignored.
- R12: man_read clocks exactly nine SCL pulses with SDA released. man_stop drives a STOP condition, and both are accepted in idle or lost.
- R13: After reset the state is 0x0, status is 0, busy is low and neither line is driven.
- R14: At most one of status bits 1 to 4 is set at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| tick | input | 1 | Bus-timing enable, one quarter bit per tick |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 32 | Count, direction, stop and run fields |
| tgt_addr | input | 7 | 7-bit target address |
| man_read | input | 1 | Manual nine-pulse read request |
| man_stop | input | 1 | Manual STOP request |
| tmo_limit | input | TMO_W | SCL-low timeout in ticks, 0 disables |
| tx_data | input | 8 | Head byte of the transmit stream |
| tx_valid | input | 1 | Transmit stream not empty |
| tx_pop | output | 1 | Consume the head transmit byte |
| rx_data | output | 8 | Received byte |
| rx_valid | output | 1 | rx_data strobe |
| scl_in | input | 1 | Resolved SCL level |
| sda_in | input | 1 | Resolved SDA level |
| scl_drv_low | output | 1 | Pull SCL low |
| sda_drv_low | output | 1 | Pull SDA low |
| state_code | output | 4 | Master state code |
| status | output | 5 | Result flags: done, abort, no-ack, no-device, timeout |
| busy | output | 1 | Master busy |

## Verification
A run command is taken on the next edge, so busy and the state code change one cycle after the strobe. Wire events follow the tick: each bit takes four ticks plus any stretch. tx_pop and rx_valid are one-cycle pulses on registered outputs. The bench therefore samples on the falling edge and never predicts an absolute edge for a wire event. Instead, a behavioural slave decodes START, STOP, bits and acknowledges from the wire, and the bench polls for busy to fall before it compares the counts, the queues and the status word. Stream pulses and the hold-state SCL level are checked on every falling edge.

// File: rtl/i2c_auto_master.sv
module i2c_auto_master #(
  parameter int CNT_W = 8,
  parameter int TMO_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cmd_valid,
  input  logic [31:0]      cmd_word,
  input  logic [6:0]       tgt_addr,
  input  logic             man_read,
  input  logic             man_stop,
  input  logic [TMO_W-1:0] tmo_limit,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_pop,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  input  logic             scl_in,
  input  logic             sda_in,
  output logic             scl_drv_low,
  output logic             sda_drv_low,
  output logic [3:0]       state_code,
  output logic [4:0]       status,
  output logic             busy
);
  localparam logic [3:0] S_IDLE = 4'h0, S_START = 4'h1, S_RESTART = 4'h2, S_STOP = 4'h3,
                         S_ADDR = 4'h5, S_READ = 4'h9, S_WRITE = 4'hA, S_LOST = 4'hC,
                         S_WAIT = 4'hD, S_HOLD = 4'hE;
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [3:0]       st;
  logic [1:0]       q;
  logic [3:0]       bpos;
  logic [7:0]       sh, rxd;
  logic [CNT_W-1:0] remain;
  logic             rd_dir, stop_en, man_op, loaded, stretch;
  logic [TMO_W-1:0] tmo_cnt;
  logic             scl_lo, sda_lo, pop_r, rxv_r;
  logic [4:0]       stat_r;

  wire cmd_run  = cmd_valid & cmd_word[31];
  wire unused_w = ^{cmd_word[30:18], cmd_word[15:CNT_W]};

  assign tx_pop      = pop_r;
  assign rx_valid    = rxv_r;
  assign rx_data     = rxd;
  assign scl_drv_low = scl_lo;
  assign sda_drv_low = sda_lo;
  assign status      = stat_r;
  assign busy        = (st != S_IDLE) && (st != S_LOST);
  assign state_code  = stretch ? S_WAIT : st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; q <= '0; bpos <= '0; sh <= '0; rxd <= '0; remain <= '0;
      rd_dir <= 1'b0; stop_en <= 1'b0; man_op <= 1'b0; loaded <= 1'b0;
      stretch <= 1'b0; tmo_cnt <= '0; scl_lo <= 1'b0; sda_lo <= 1'b0;
      pop_r <= 1'b0; rxv_r <= 1'b0; stat_r <= '0;
    end else begin
      pop_r <= 1'b0;
      rxv_r <= 1'b0;
      case (st)
        S_IDLE, S_LOST: begin
          scl_lo <= 1'b0; sda_lo <= 1'b0; q <= '0; bpos <= '0;
          if (man_stop) st <= S_STOP;
          else if (man_read) begin st <= S_READ; man_op <= 1'b1; end
          else if (st == S_IDLE && cmd_run) begin
            remain <= cmd_word[CNT_W-1:0]; rd_dir <= cmd_word[16]; stop_en <= cmd_word[17];
            sh <= {tgt_addr, cmd_word[16]}; stat_r <= '0; loaded <= 1'b0;
            st <= S_START;
          end else st <= sda_in ? S_IDLE : S_LOST;
        end
        S_HOLD: begin
          if (man_stop) begin st <= S_STOP; q <= '0; end
          else if (cmd_run) begin
            remain <= cmd_word[CNT_W-1:0]; rd_dir <= cmd_word[16]; stop_en <= cmd_word[17];
            sh <= {tgt_addr, cmd_word[16]}; stat_r <= '0; loaded <= 1'b0;
            q <= '0; bpos <= '0; st <= S_RESTART;
          end
        end
        S_START: if (tick) begin
          if (q == 2'd0) begin sda_lo <= 1'b1; q <= 2'd1; end
          else begin scl_lo <= 1'b1; q <= '0; bpos <= '0; st <= S_ADDR; end
        end
        S_RESTART: if (tick) begin
          case (q)
            2'd0: sda_lo <= 1'b0;
            2'd1: scl_lo <= 1'b0;
            2'd2: sda_lo <= 1'b1;
            default: begin scl_lo <= 1'b1; bpos <= '0; st <= S_ADDR; end
          endcase
          q <= q + 2'd1;
        end
        S_STOP: if (tick) begin
          case (q)
            2'd0: scl_lo <= 1'b1;
            2'd1: sda_lo <= 1'b1;
            2'd2: scl_lo <= 1'b0;
            default: begin sda_lo <= 1'b0; man_op <= 1'b0; st <= S_IDLE; end
          endcase
          q <= q + 2'd1;
        end
        S_ADDR, S_WRITE, S_READ: if (tick) begin
          case (q)
            2'd0: begin
              scl_lo <= 1'b1;
              if (st == S_WRITE && !loaded) begin
                if (tx_valid) begin sh <= tx_data; pop_r <= 1'b1; loaded <= 1'b1; end
              end else q <= 2'd1;
            end
            2'd1: begin
              if (bpos < 4'd8) sda_lo <= (st == S_READ) ? 1'b0 : ~sh[7];
              else sda_lo <= (st == S_READ && !man_op) ? (remain != ONE) : 1'b0;
              q <= 2'd2;
            end
            2'd2: begin scl_lo <= 1'b0; q <= 2'd3; end
            default: begin
              if (!scl_in) begin
                if (tmo_limit != '0 && tmo_cnt == tmo_limit) begin
                  stat_r[4] <= 1'b1; scl_lo <= 1'b0; sda_lo <= 1'b0;
                  stretch <= 1'b0; tmo_cnt <= '0; man_op <= 1'b0; st <= S_IDLE;
                end else begin
                  stretch <= 1'b1; tmo_cnt <= tmo_cnt + 1'b1;
                end
              end else begin
                stretch <= 1'b0; tmo_cnt <= '0; q <= '0;
                if (bpos < 4'd8) begin
                  if (st != S_READ && !sda_lo && !sda_in) begin
                    stat_r[1] <= 1'b1; scl_lo <= 1'b0; sda_lo <= 1'b0; st <= S_LOST;
                  end else begin
                    sh <= {sh[6:0], sda_in};
                    bpos <= bpos + 4'd1;
                    if (st == S_READ && !man_op && bpos == 4'd7) begin
                      rxd <= {sh[6:0], sda_in}; rxv_r <= 1'b1;
                    end
                  end
                end else begin
                  bpos <= '0;
                  loaded <= 1'b0;
                  if (man_op) begin
                    man_op <= 1'b0; st <= S_IDLE;
                  end else if (st == S_ADDR && sda_in) begin
                    stat_r[3] <= 1'b1; st <= S_STOP;
                  end else if (st == S_WRITE && sda_in) begin
                    stat_r[2] <= 1'b1; st <= S_STOP;
                  end else if ((st == S_ADDR && remain == '0) || (st != S_ADDR && remain == ONE)) begin
                    remain <= '0; stat_r[0] <= 1'b1;
                    if (stop_en) st <= S_STOP;
                    else begin st <= S_HOLD; scl_lo <= 1'b1; sda_lo <= 1'b0; end
                  end else if (st == S_ADDR) begin
                    st <= rd_dir ? S_READ : S_WRITE;
                  end else remain <= remain - ONE;
                end
              end
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/i2c_auto_master_chk.sv
module i2c_auto_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] state_code,
  input logic [4:0] status,
  input logic       busy,
  input logic       scl_drv_low,
  input logic       sda_drv_low,
  input logic       tx_pop,
  input logic       rx_valid
);
  AST_TXPOP_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n) tx_pop |-> state_code == 4'hA); // R2
  AST_RXV_IN_READ: assert property (@(posedge clk) disable iff (!rst_n) rx_valid |-> state_code == 4'h9); // R3
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) state_code == 4'h0 |-> (!busy && !scl_drv_low && !sda_drv_low)); // R4
  AST_HOLD_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n) state_code == 4'hE |-> (scl_drv_low && busy)); // R5
  AST_LOST_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) state_code == 4'hC |-> (!scl_drv_low && !sda_drv_low)); // R8
  AST_ONE_ERROR: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(status[4:1])); // R14
endmodule

bind i2c_auto_master i2c_auto_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .state_code(state_code), .status(status), .busy(busy),
  .scl_drv_low(scl_drv_low), .sda_drv_low(sda_drv_low), .tx_pop(tx_pop), .rx_valid(rx_valid)
);

// File: tb/i2c_auto_master_bench.sv
module i2c_auto_master_bench;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic cmd_valid = 1'b0, man_read = 1'b0, man_stop = 1'b0;
  logic [31:0] cmd_word = '0;
  logic [6:0] tgt_addr = 7'h50;
  logic [7:0] tmo_limit = 8'd0;
  logic [7:0] tx_data;
  logic tx_valid, tx_pop, rx_valid, scl_drv_low, sda_drv_low, busy;
  logic [7:0] rx_data;
  logic [3:0] state_code;
  logic [4:0] status;
  logic s_scl = 1'b0, s_sda = 1'b0;
  wire scl = !(scl_drv_low | s_scl);
  wire sda = !(sda_drv_low | s_sda);

  byte unsigned txq[$], rxexp[$], wrq[$], rdq[$];
  int tests = 0, fails = 0, cycles = 0;
  int nstart = 0, nstop = 0, nrise = 0, macks = 0, mnacks = 0;
  int mode = 0, pend = 0, bpos = 0, wcnt = 0, nack_at = -1;
  int stretch_len = 0, stretch_left = 0, stuck_rises = 0;
  logic stuck = 1'b0, clash = 1'b0, release_req = 1'b0, lastnack = 1'b0, seen_wait = 1'b0;
  logic scl_p = 1'b1, sda_p = 1'b1;
  byte unsigned sh = 0, rdb = 0, last_addr = 0;

  assign tx_valid = txq.size() != 0;
  assign tx_data  = tx_valid ? txq[0] : 8'h00;

  i2c_auto_master u_i2c_auto_master (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
    .tgt_addr(tgt_addr), .man_read(man_read), .man_stop(man_stop), .tmo_limit(tmo_limit),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_pop(tx_pop), .rx_data(rx_data),
    .rx_valid(rx_valid), .scl_in(scl), .sda_in(sda), .scl_drv_low(scl_drv_low),
    .sda_drv_low(sda_drv_low), .state_code(state_code), .status(status), .busy(busy));

  always #10 clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // clock-by-clock reference checks and behavioural slave
  always @(negedge clk) begin
    logic rise, fall;
    cycles++;
    if (rst_n) tick <= ~tick;
    if (cycles > 150000) begin
      fails++; tests++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
    if (rst_n && tx_pop) begin
      if (txq.size() == 0) chk("R2 pop on empty", 1, 0); else void'(txq.pop_front());
    end
    if (rst_n && rx_valid) begin
      if (rxexp.size() == 0) chk("R3 unexpected rx", 1, 0);
      else chk("R3 rx byte", rx_data, rxexp.pop_front());
    end
    if (rst_n && state_code == 4'hE && !scl_drv_low) chk("R5 hold scl", 0, 1);
    if (state_code == 4'hD) seen_wait = 1'b1;

    rise = scl && !scl_p;
    fall = !scl && scl_p;
    if (rise) nrise++;
    if (stretch_left > 0) begin
      stretch_left--;
      if (stretch_left == 0) s_scl = 1'b0;
    end
    if (release_req) begin
      s_sda = 1'b0; mode = 0; release_req = 1'b0;
    end else if (stuck) begin
      s_sda = 1'b1;
      if (rise) begin
        stuck_rises++;
        if (stuck_rises == 9) begin stuck = 1'b0; s_sda = 1'b0; end
      end
    end else if (scl && scl_p && sda_p && !sda) begin
      nstart++; mode = 1; bpos = 0; wcnt = 0; s_sda = 1'b0;
    end else if (scl && scl_p && !sda_p && sda) begin
      nstop++; mode = 0; s_sda = 1'b0;
    end else if (mode != 0) begin
      if (rise) begin
        if (bpos < 8) begin sh = {sh[6:0], sda}; bpos++; end
        else if (bpos == 8) begin
          if (mode == 3) begin
            lastnack = sda;
            if (sda) mnacks++; else macks++;
          end
          bpos = 9;
        end
      end else if (fall) begin
        if (bpos == 8) begin
          if (stretch_len > 0) begin s_scl = 1'b1; stretch_left = stretch_len; end
          if (mode == 1) begin
            last_addr = sh;
            if (sh[7:1] == 7'h50) begin s_sda = 1'b1; pend = sh[0] ? 3 : 2; end
            else begin s_sda = 1'b0; pend = 4; end
          end else if (mode == 2) begin
            wrq.push_back(sh); s_sda = (wcnt != nack_at); wcnt++; pend = 2;
          end else begin s_sda = 1'b0; pend = mode; end
        end else if (bpos == 9) begin
          bpos = 0; s_sda = 1'b0;
          if (mode == 3 && lastnack) pend = 4;
          mode = pend;
          if (mode == 3) begin
            rdb = (rdq.size() != 0) ? rdq.pop_front() : 8'hFF;
            s_sda = !rdb[7];
          end
          if (mode == 2 && clash) s_sda = 1'b1;
        end else if (bpos >= 1) begin
          if (mode == 3) s_sda = !rdb[7-bpos];
          else if (mode == 2 && clash) s_sda = 1'b1;
          else s_sda = 1'b0;
        end
      end
    end
    scl_p = scl;
    sda_p = sda;
  end

  task automatic run(input logic [6:0] a, input int cnt, input bit rd, input bit stp);
    @(negedge clk);
    tgt_addr = a;
    cmd_word = 32'h8000_0000 | (32'(stp) << 17) | (32'(rd) << 16) | 32'(cnt);
    cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_free();
    for (int i = 0; i < 8000 && busy; i++) @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    int s0, p0, r0;
    idle(3);
    chk("R13 state", state_code, 0); chk("R13 status", status, 0);
    chk("R13 busy", busy, 0); chk("R13 lines", {scl_drv_low, sda_drv_low}, 0);
    rst_n = 1'b1;
    idle(4);

    // R1 R2 R4: write three bytes with STOP
    txq = '{8'hA1, 8'hB2, 8'hC3}; wrq.delete(); s0 = nstart; p0 = nstop;
    run(7'h50, 3, 0, 1);
    chk("R4 busy after command", busy, 1);
    wait_free(); idle(2);
    chk("R1 write address byte", last_addr, 8'hA0);
    chk("R2 bytes written", wrq.size(), 3);
    if (wrq.size() == 3) begin
      chk("R2 byte0", wrq[0], 8'hA1); chk("R2 byte1", wrq[1], 8'hB2); chk("R2 byte2", wrq[2], 8'hC3);
    end
    chk("R2 done", status, 5'h01);
    chk("R4 one stop", nstop - p0, 1); chk("R4 one start", nstart - s0, 1);
    chk("R4 idle", state_code, 0);

    // R3: read four bytes
    rdq = '{8'h11, 8'h22, 8'h33, 8'h44}; rxexp = '{8'h11, 8'h22, 8'h33, 8'h44};
    macks = 0; mnacks = 0;
    run(7'h50, 4, 1, 1);
    wait_free(); idle(2);
    chk("R1 read address byte", last_addr, 8'hA1);
    chk("R3 all rx taken", rxexp.size(), 0);
    chk("R3 acks", macks, 3); chk("R3 final nack", mnacks, 1);
    chk("R3 done", status, 5'h01);

    // R5: write without STOP, then repeated START read
    txq = '{8'h5A, 8'hC3}; wrq.delete(); s0 = nstart; p0 = nstop;
    run(7'h50, 2, 0, 0);
    for (int i = 0; i < 4000 && state_code != 4'hE; i++) @(negedge clk);
    idle(3);
    chk("R5 hold state", state_code, 4'hE); chk("R5 busy held", busy, 1);
    chk("R5 scl low", scl_drv_low, 1); chk("R5 no stop", nstop - p0, 0);
    chk("R5 done", status, 5'h01);
    rdq = '{8'h9C}; rxexp = '{8'h9C}; mnacks = 0;
    run(7'h50, 1, 1, 1);
    wait_free(); idle(2);
    chk("R5 repeated start", nstart - s0, 2); chk("R5 stop at end", nstop - p0, 1);
    chk("R5 read after restart", rxexp.size(), 0); chk("R3 single nack", mnacks, 1);

    // R6: address not answered
    txq = '{8'h55, 8'h66}; p0 = nstop;
    run(7'h33, 2, 0, 1);
    wait_free(); idle(2);
    chk("R6 no-device", status, 5'h08); chk("R6 no pop", txq.size(), 2);
    chk("R6 stop", nstop - p0, 1);
    txq.delete();

    // R7: second data byte refused, stop flag clear
    txq = '{8'h01, 8'h02, 8'h03}; wrq.delete(); nack_at = 1; p0 = nstop;
    run(7'h50, 3, 0, 0);
    wait_free(); idle(2);
    chk("R7 no-ack", status, 5'h04); chk("R7 bytes sent", wrq.size(), 2);
    chk("R7 stop", nstop - p0, 1); chk("R7 idle", state_code, 0);
    nack_at = -1; txq.delete();

    // R10: stretch inside the limit
    txq = '{8'h77}; wrq.delete(); stretch_len = 10; tmo_limit = 8'd20; seen_wait = 1'b0;
    run(7'h50, 1, 0, 1);
    wait_free(); idle(24);
    chk("R10 done after stretch", status, 5'h01); chk("R10 wait code seen", seen_wait, 1);
    chk("R10 byte", wrq.size(), 1);

    // R9: stretch beyond the limit
    stretch_len = 200; tmo_limit = 8'd10;
    run(7'h33, 1, 0, 1);
    wait_free();
    chk("R9 timeout", status, 5'h10); chk("R9 busy low", busy, 0);
    chk("R9 released", {scl_drv_low, sda_drv_low}, 0);
    stretch_len = 0; tmo_limit = 8'd0;
    idle(260);
    txq.delete();

    // R8: arbitration lost on first data bit
    txq = '{8'hFF}; clash = 1'b1;
    run(7'h50, 1, 0, 1);
    wait_free(); idle(2);
    chk("R8 abort flag", status, 5'h02); chk("R8 lost code", state_code, 4'hC);
    chk("R8 released", {scl_drv_low, sda_drv_low}, 0);
    clash = 1'b0; release_req = 1'b1;
    idle(4);
    chk("R8 back to idle", state_code, 0);
    txq.delete();

    // R11 R12: stuck SDA, ignored run, recovery
    stuck_rises = 0; stuck = 1'b1;
    idle(4);
    chk("R11 lost while sda low", state_code, 4'hC);
    s0 = nstart;
    run(7'h50, 1, 0, 1);
    idle(20);
    chk("R11 run ignored", nstart - s0, 0); chk("R11 still lost", state_code, 4'hC);
    chk("R11 not busy", busy, 0);
    r0 = nrise;
    @(negedge clk); man_read = 1'b1; @(negedge clk); man_read = 1'b0;
    wait_free(); idle(3);
    chk("R12 nine pulses", nrise - r0, 9); chk("R12 bus freed", state_code, 0);
    p0 = nstop;
    @(negedge clk); man_stop = 1'b1; @(negedge clk); man_stop = 1'b0;
    wait_free(); idle(3);
    chk("R12 manual stop", nstop - p0, 1); chk("R12 idle", state_code, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule